// File: doc/BRIEF.md
# Combinational Arithmetic-Logic Unit with Error Code

This block is a combinational arithmetic-logic unit for a 32-bit datapath. It takes two operands and a 4-bit operation selector. It returns a 32-bit result and a 4-bit error code. The error code separates overflow, underflow and divide-by-zero. The unit holds no state and has no clock. Both outputs follow any change on any input within the same evaluation.

The arithmetic group covers the following operations:

- unsigned add and subtract
- signed (two's complement) add, subtract, multiply and divide

The logic group pairs each boolean-style operation with a bitwise counterpart: AND, OR and NOT in both forms. For subtract and divide, operand A is the left-hand side. The NOT operations read operand A only. The four highest selector codes give an all-zero result with no error.

The logic is split into three units. An adder/subtractor and a multiplier/divider each produce their own result and error. A logic unit produces a result only. A final selector picks the pair that the operation code names.

Top module: `alu_core`

## Requirements
- R1: Selector 0000 gives the low 32 bits of A+B (unsigned). The error code is 0001 (overflow) when the sum carries out of bit 31, and 0000 otherwise.
- R2: Selector 0001 gives the low 32 bits of A−B. The error code is 0010 (underflow) when B is greater than A as unsigned values, and 0000 otherwise.
- R3: Selector 0010 gives the low 32 bits of signed A+B, and selector 0011 gives the low 32 bits of signed A−B. The error code is 0001 when the exact result is above 2^31−1, 0010 when it is below −2^31, and 0000 otherwise.
- R4: Selector 0100 gives the low 32 bits of the signed 64-bit product A×B. The error code is 0001 when that product is above 2^31−1, 0010 when it is below −2^31, and 0000 otherwise.
- R5: Selector 0101 gives signed A/B truncated toward zero. When B is zero, the result is 0 and the error code is 0011. When A is −2^31 and B is −1, the result is 32'h80000000 and the error code is 0001.
- R6: Selector 0110 (logical AND) and selector 1000 (logical OR) treat any nonzero operand as true. They return 32'h00000001 for true and 32'h00000000 for false.
- R7: Selector 0111 gives A&B and selector 1001 gives A|B.
- R8: Selector 1010 gives 1 when A is zero and 0 otherwise. Selector 1011 gives ~A. Operand B has no effect on either.
- R9: Selectors 1100 through 1111 give an all-zero result. These selectors, and every logical or bitwise selector, always give error code 0000.
- R10: Both outputs change whenever any input changes, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | Left operand; the only operand read by the NOT operations |
| opnd_b | input | 32 | Right operand |
| op_sel | input | 4 | Operation selector |
| res | output | 32 | Operation result |
| err_code | output | 4 | 0000 none, 0001 overflow, 0010 underflow, 0011 divide by zero |

## Verification
The bench targets the sign boundaries of each operation:

- 2^31−1 + 1 and −2^31 − 1 for signed add and subtract. A unit that checks only the carry out would flag the wrong direction, or miss these cases.
- Products of exactly ±2^32 and +2^31. Their low word looks harmless, so a unit that judged overflow on the truncated product would report no error.
- −2^31 / −1, and division by zero with both a nonzero and a zero dividend. Division by zero must give a zero result rather than a garbage quotient.
- Equal operands for unsigned subtract. A greater-or-equal comparison here would raise a false underflow.

The NOT operations run with two different B values, which would expose any use of B. The reserved selectors run with all-ones operands, which would expose any leak from the arithmetic units.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OPW  = 4;
    localparam int ERRW = 4;

    typedef enum logic [OPW-1:0] {
        OP_UADD = 4'd0,
        OP_USUB = 4'd1,
        OP_SADD = 4'd2,
        OP_SSUB = 4'd3,
        OP_SMUL = 4'd4,
        OP_SDIV = 4'd5,
        OP_LAND = 4'd6,
        OP_BAND = 4'd7,
        OP_LOR  = 4'd8,
        OP_BOR  = 4'd9,
        OP_LNOT = 4'd10,
        OP_BNOT = 4'd11,
        OP_RSV0 = 4'd12,
        OP_RSV1 = 4'd13,
        OP_RSV2 = 4'd14,
        OP_RSV3 = 4'd15
    } op_e;

    typedef enum logic [ERRW-1:0] {
        ER_NONE = 4'd0,
        ER_OVF  = 4'd1,
        ER_UNF  = 4'd2,
        ER_DIVZ = 4'd3
    } err_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] sum,
    output err_e         err
);

    logic [W:0] uwide;
    logic [W:0] swide;

    always_comb begin
        uwide = '0;
        swide = '0;
        sum   = '0;
        err   = ER_NONE;
        unique case (op)
            OP_UADD: begin
                uwide = {1'b0, a} + {1'b0, b};
                sum   = uwide[W-1:0];
                err   = uwide[W] ? ER_OVF : ER_NONE;
            end
            OP_USUB: begin
                sum = a - b;
                err = (b > a) ? ER_UNF : ER_NONE;
            end
            OP_SADD, OP_SSUB: begin
                if (op == OP_SADD) swide = {a[W-1], a} + {b[W-1], b};
                else               swide = {a[W-1], a} - {b[W-1], b};
                sum = swide[W-1:0];
                unique case (swide[W:W-1])
                    2'b01:   err = ER_OVF;
                    2'b10:   err = ER_UNF;
                    default: err = ER_NONE;
                endcase
            end
            default: begin
                sum = '0;
                err = ER_NONE;
            end
        endcase
    end

endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] out,
    output err_e         err
);

    localparam int PW = 2 * W;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic [W:0]           prod_top;
    logic                 b_zero;
    logic                 min_by_neg1;
    logic [W-1:0]         b_safe;
    logic signed [W-1:0]  quo;

    assign prod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    assign prod_top = prod[PW-1:W-1];
    assign b_zero = (b == '0);
    assign min_by_neg1 = (a == MINV) && (b == '1);
    assign b_safe = (b_zero || min_by_neg1) ? {{(W-1){1'b0}}, 1'b1} : b;
    assign quo = $signed(a) / $signed(b_safe);

    always_comb begin
        out = '0;
        err = ER_NONE;
        unique case (op)
            OP_SMUL: begin
                out = prod[W-1:0];
                if ((prod_top == '0) || (prod_top == '1)) err = ER_NONE;
                else if (prod[PW-1])                      err = ER_UNF;
                else                                      err = ER_OVF;
            end
            OP_SDIV: begin
                if (b_zero) begin
                    out = '0;
                    err = ER_DIVZ;
                end else if (min_by_neg1) begin
                    out = MINV;
                    err = ER_OVF;
                end else begin
                    out = quo;
                    err = ER_NONE;
                end
            end
            default: begin
                out = '0;
                err = ER_NONE;
            end
        endcase
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] out
);

    localparam logic [W-1:0] TRUEV  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] FALSEV = '0;

    logic a_true;
    logic b_true;

    assign a_true = |a;
    assign b_true = |b;

    always_comb begin
        out = '0;
        unique case (op)
            OP_LAND: out = (a_true && b_true) ? TRUEV : FALSEV;
            OP_BAND: out = a & b;
            OP_LOR:  out = (a_true || b_true) ? TRUEV : FALSEV;
            OP_BOR:  out = a | b;
            OP_LNOT: out = a_true ? FALSEV : TRUEV;
            OP_BNOT: out = ~a;
            default: out = '0;
        endcase
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic [OPW-1:0]  op_sel,
    output logic [W-1:0]    res,
    output logic [ERRW-1:0] err_code
);

    op_e          op;
    logic [W-1:0] as_res;
    err_e         as_err;
    logic [W-1:0] md_res;
    err_e         md_err;
    logic [W-1:0] lg_res;

    assign op = op_e'(op_sel);

    alu_addsub #(.W(W)) u_addsub (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (op),
        .sum (as_res),
        .err (as_err)
    );

    alu_muldiv #(.W(W)) u_muldiv (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (op),
        .out (md_res),
        .err (md_err)
    );

    alu_logic #(.W(W)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (op),
        .out (lg_res)
    );

    always_comb begin
        res      = '0;
        err_code = ER_NONE;
        unique case (op)
            OP_UADD, OP_USUB, OP_SADD, OP_SSUB: begin
                res      = as_res;
                err_code = as_err;
            end
            OP_SMUL, OP_SDIV: begin
                res      = md_res;
                err_code = md_err;
            end
            OP_LAND, OP_BAND, OP_LOR, OP_BOR, OP_LNOT, OP_BNOT: begin
                res      = lg_res;
                err_code = ER_NONE;
            end
            OP_RSV0, OP_RSV1, OP_RSV2, OP_RSV3: begin
                res      = '0;
                err_code = ER_NONE;
            end
            default: begin
                res      = '0;
                err_code = ER_NONE;
            end
        endcase
    end

    // Output-level checks against the selected sub-unit results
    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b})) begin
            // R9: reserved selectors give zero result and no error
            a_r9_reserved_zero: assert (!(op_sel >= 4'd12) || (res == '0 && err_code == 4'd0));
            // R9: logic and bitwise selectors never flag an error
            a_r9_logic_no_err: assert (!(op_sel inside {[4'd6:4'd11]}) || err_code == 4'd0);
            // R6: boolean-style results are 0 or 1 only
            a_r6_bool_range: assert (!(op_sel inside {4'd6, 4'd8, 4'd10}) || res[W-1:1] == '0);
            // R5: divide by zero returns a zero result
            a_r5_divz_zero: assert (!(op_sel == 4'd5 && err_code == 4'd3) || res == '0);
            // R1: a carry out means the wrapped sum is below operand A
            a_r1_carry_wraps: assert (!(op_sel == 4'd0 && err_code == 4'd1) || res < opnd_a);
            // R2: an underflow flag implies B exceeds A
            a_r2_unf_order: assert (!(op_sel == 4'd1 && err_code == 4'd2) || opnd_b > opnd_a);
        end
    end

endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;

    logic        clk;
    logic        rst;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [3:0]  op_sel;
    logic [31:0] res;
    logic [3:0]  err_code;

    int total;
    int bad;

    alu_core u0 (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .op_sel   (op_sel),
        .res      (res),
        .err_code (err_code)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] er, input logic [3:0] ee);
        total++;
        if (res !== er || err_code !== ee) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h: res=%h err=%h expected res=%h err=%h",
                     tag, op_sel, opnd_a, opnd_b, res, err_code, er, ee);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        #2;
    endtask

    task automatic t_uadd();
        apply(4'd0, 32'd5, 32'd7);                 chk("R1 plain", 32'd12, 4'd0);
        apply(4'd0, 32'hFFFFFFFF, 32'd2);          chk("R1 carry", 32'd1, 4'd1);
        apply(4'd0, 32'h80000000, 32'h80000000);   chk("R1 carry zero", 32'd0, 4'd1);
    endtask

    task automatic t_usub();
        apply(4'd1, 32'd10, 32'd3);                chk("R2 plain", 32'd7, 4'd0);
        apply(4'd1, 32'd3, 32'd10);                chk("R2 under", 32'hFFFFFFF9, 4'd2);
        apply(4'd1, 32'd5, 32'd5);                 chk("R2 equal", 32'd0, 4'd0);
    endtask

    task automatic t_saddsub();
        apply(4'd2, 32'hFFFFFFFB, 32'd3);          chk("R3 add plain", 32'hFFFFFFFE, 4'd0);
        apply(4'd2, 32'h7FFFFFFF, 32'd1);          chk("R3 add ovf", 32'h80000000, 4'd1);
        apply(4'd2, 32'h80000000, 32'hFFFFFFFF);   chk("R3 add unf", 32'h7FFFFFFF, 4'd2);
        apply(4'd2, 32'hFFFFFFFF, 32'hFFFFFFFF);   chk("R3 add neg", 32'hFFFFFFFE, 4'd0);
        apply(4'd3, 32'd3, 32'd5);                 chk("R3 sub plain", 32'hFFFFFFFE, 4'd0);
        apply(4'd3, 32'h80000000, 32'd1);          chk("R3 sub unf", 32'h7FFFFFFF, 4'd2);
        apply(4'd3, 32'h7FFFFFFF, 32'hFFFFFFFF);   chk("R3 sub ovf", 32'h80000000, 4'd1);
    endtask

    task automatic t_smul();
        apply(4'd4, 32'hFFFFFFFD, 32'd7);          chk("R4 plain", 32'hFFFFFFEB, 4'd0);
        apply(4'd4, 32'h00010000, 32'h00010000);   chk("R4 ovf 2^32", 32'd0, 4'd1);
        apply(4'd4, 32'h00010000, 32'hFFFF0000);   chk("R4 unf -2^32", 32'd0, 4'd2);
        apply(4'd4, 32'h40000000, 32'd2);          chk("R4 ovf 2^31", 32'h80000000, 4'd1);
        apply(4'd4, 32'hC0000000, 32'd2);          chk("R4 min fits", 32'h80000000, 4'd0);
    endtask

    task automatic t_sdiv();
        apply(4'd5, 32'hFFFFFFF9, 32'd2);          chk("R5 neg trunc", 32'hFFFFFFFD, 4'd0);
        apply(4'd5, 32'd7, 32'hFFFFFFFE);          chk("R5 negdiv trunc", 32'hFFFFFFFD, 4'd0);
        apply(4'd5, 32'd100, 32'd7);               chk("R5 pos", 32'd14, 4'd0);
        apply(4'd5, 32'd5, 32'd0);                 chk("R5 divz", 32'd0, 4'd3);
        apply(4'd5, 32'd0, 32'd0);                 chk("R5 zero divz", 32'd0, 4'd3);
        apply(4'd5, 32'h80000000, 32'hFFFFFFFF);   chk("R5 min/-1", 32'h80000000, 4'd1);
    endtask

    task automatic t_logic();
        apply(4'd6, 32'd5, 32'd0);                 chk("R6 land false", 32'd0, 4'd0);
        apply(4'd6, 32'd5, 32'h80000000);          chk("R6 land true", 32'd1, 4'd0);
        apply(4'd8, 32'd0, 32'd0);                 chk("R6 lor false", 32'd0, 4'd0);
        apply(4'd8, 32'd0, 32'h100);               chk("R6 lor true", 32'd1, 4'd0);
        apply(4'd7, 32'h0000F0F0, 32'h0000FF00);   chk("R7 band", 32'h0000F000, 4'd0);
        apply(4'd9, 32'h0000F0F0, 32'h0000FF00);   chk("R7 bor", 32'h0000FFF0, 4'd0);
    endtask

    task automatic t_not();
        apply(4'd10, 32'd0, 32'hFFFFFFFF);         chk("R8 lnot zero", 32'd1, 4'd0);
        apply(4'd10, 32'd0, 32'd0);                chk("R8 lnot b ignored", 32'd1, 4'd0);
        apply(4'd10, 32'd8, 32'd0);                chk("R8 lnot nonzero", 32'd0, 4'd0);
        apply(4'd11, 32'h0F0F0F0F, 32'd0);         chk("R8 bnot", 32'hF0F0F0F0, 4'd0);
        apply(4'd11, 32'h0F0F0F0F, 32'hFFFFFFFF);  chk("R8 bnot b ignored", 32'hF0F0F0F0, 4'd0);
    endtask

    task automatic t_reserved();
        for (int k = 12; k < 16; k++) begin
            apply(4'(k), 32'hFFFFFFFF, 32'hFFFFFFFF);
            chk("R9 reserved", 32'd0, 4'd0);
        end
    endtask

    task automatic t_comb();
        apply(4'd0, 32'd1, 32'd1);                 chk("R10 base", 32'd2, 4'd0);
        opnd_b = 32'd40;
        #1;                                        chk("R10 b change", 32'd41, 4'd0);
        op_sel = 4'd1;
        #1;                                        chk("R10 op change", 32'hFFFFFFD9, 4'd2);
    endtask

    initial begin
        total  = 0;
        bad    = 0;
        rst    = 1'b1;
        op_sel = 4'd0;
        opnd_a = 32'd0;
        opnd_b = 32'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", 32'd0, 4'd0);
        rst = 1'b0;
        t_uadd();
        t_usub();
        t_saddsub();
        t_smul();
        t_sdiv();
        t_logic();
        t_not();
        t_reserved();
        t_comb();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule